// File: doc/BRIEF.md
# DMA Command-Queue Register Interface

This block is the software-facing register front end of a DMA engine's command queue. It stores a queue base word, an end pointer, a write pointer and a read pointer. It also holds an interrupt enable word and an interrupt status word, and it drives a level-sensitive interrupt line. The bus is a simple single-cycle word port: a request with the write flag stores `wr_data` in the addressed word, and a request without it returns the addressed word one cycle later with `rd_valid`.

Writing the write pointer stands in for the engine finishing a batch. The masked pointer is copied into the read pointer, and both completion status bits (upstream bit 4 and downstream bit 5) are raised. The interrupt line goes high if either matching enable bit is set. Software can prevent one such report in advance by writing a fixed arming word to the read-pointer offset. The next write-pointer write then only moves the pointers.

Two small state machines carry the sequencing. The suppression machine has states `SUP_IDLE` and `SUP_ARMED`. Transition *arm* (`SUP_IDLE` to `SUP_ARMED`) fires on an arming-word write to the read-pointer offset. Transition *consume* (`SUP_ARMED` to `SUP_IDLE`) fires on the next write-pointer write. The interrupt machine has states `IRQ_LOW` and `IRQ_HIGH`. Transition *raise* fires on a completion while an enable bit is set. Transition *drop* fires on a status write that carries bit 4 or bit 5.

Top module: `dmaq_regif`

## Requirements
- R1: After reset every stored word reads zero, except the status word (word index 9, byte offset 0x24), which reads 0xF8000000. The interrupt line and `rd_valid` are low.
- R2: A read request returns the addressed word on `rd_data` with `rd_valid` high exactly one cycle later. `rd_valid` is low in every other cycle.
- R3: A write to the end pointer (word index 5) keeps only bits 17:0 of `wr_data`.
- R4: A write to the write pointer (word index 6) stores bits 17:0 of `wr_data` and copies the same value into the read pointer (word index 7).
- R5: A write to the read pointer never changes its stored value. Only the value 0xEE882266 arms suppression, and any other value has no effect.
- R6: A write-pointer write while not armed sets status bits 4 and 5. If enable bit 4 or bit 5 (word index 8) is set, the interrupt line is high from the next cycle.
- R7: A write-pointer write while armed leaves the status word and the interrupt line unchanged and disarms, so the following write-pointer write completes normally.
- R8: A write to the enable word keeps only the bits of 0xBFEFF07F.
- R9: A status write with bit 4 or bit 5 set clears both bits and drops the interrupt line. No status write changes any other status bit.
- R10: Any other word index below 32 (including the base word at index 4) stores all 32 bits as written.
- R11: Word indices 32 and above ignore writes, do not alias onto lower words, and read as zero.
- R12: A completion with both enable bits clear still sets status bits 4 and 5 but leaves the interrupt line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | BUS_AW | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data strobe, one cycle after a read request |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench uses the default parameters: a 10-bit word address over a 32-word array. This leaves nearly a thousand word addresses above the array. It can therefore write just past the top (index 32 and 36) and read the last possible address (1023), to show that nothing aliases onto words 0 and 4. The array's last word (31) is also checked as ordinary storage. These values also place every special word within reach of the same bus, so the arm/consume and raise/drop sequences can be run back to back.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    localparam int unsigned WORD_W = 32;

    // Word indices of the special registers (byte offset / 4)
    localparam int unsigned IDX_BASE = 4;
    localparam int unsigned IDX_END  = 5;
    localparam int unsigned IDX_WRP  = 6;
    localparam int unsigned IDX_RDP  = 7;
    localparam int unsigned IDX_CTRL = 8;
    localparam int unsigned IDX_STAT = 9;

    localparam logic [WORD_W-1:0] PTR_KEEP   = 32'h0003_FFFF;
    localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'hBFEF_F07F;
    localparam logic [WORD_W-1:0] STAT_INIT  = 32'hF800_0000;
    localparam logic [WORD_W-1:0] ARM_WORD   = 32'hEE88_2266;
    localparam logic [WORD_W-1:0] DONE_BITS  = 32'h0000_0030;

    typedef enum logic {
        SUP_IDLE  = 1'b0,
        SUP_ARMED = 1'b1
    } sup_state_e;

    typedef enum logic {
        IRQ_LOW  = 1'b0,
        IRQ_HIGH = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic wr_end;
        logic wr_wrp;
        logic wr_rdp;
        logic wr_ctrl;
        logic wr_stat;
        logic wr_plain;
        logic rd;
        logic in_range;
    } bus_dec_t;

endpackage

// File: rtl/dmaq_bus_decode.sv
module dmaq_bus_decode
    import dmaq_pkg::*;
#(
    parameter int unsigned BUS_AW    = 10,
    parameter int unsigned NUM_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              req,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    output bus_dec_t          dec,
    output logic [IDX_W-1:0]  idx
);

    logic wr_any;

    always_comb begin
        idx          = addr[IDX_W-1:0];
        dec          = '0;
        dec.in_range = ({1'b0, addr} < (BUS_AW+1)'(NUM_WORDS));
        wr_any       = req && we && dec.in_range;
        dec.rd       = req && !we;
        if (wr_any) begin
            unique case (int'(idx))
                IDX_END:  dec.wr_end   = 1'b1;
                IDX_WRP:  dec.wr_wrp   = 1'b1;
                IDX_RDP:  dec.wr_rdp   = 1'b1;
                IDX_CTRL: dec.wr_ctrl  = 1'b1;
                IDX_STAT: dec.wr_stat  = 1'b1;
                default:  dec.wr_plain = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/dmaq_suppress_fsm.sv
module dmaq_suppress_fsm
    import dmaq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_write,
    input  logic wrp_write,
    output logic armed,
    output logic complete
);

    sup_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SUP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_IDLE:  if (arm_write) state_d = SUP_ARMED;   // arm
            SUP_ARMED: if (wrp_write) state_d = SUP_IDLE;    // consume
        endcase
    end

    always_comb begin
        armed    = (state_q == SUP_ARMED);
        complete = wrp_write && (state_q == SUP_IDLE);
    end

endmodule

// File: rtl/dmaq_irq_fsm.sv
module dmaq_irq_fsm
    import dmaq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic complete,
    input  logic enable_any,
    input  logic clear,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_LOW:  if (complete && enable_any) state_d = IRQ_HIGH;  // raise
            IRQ_HIGH: if (clear && !complete)     state_d = IRQ_LOW;   // drop
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_HIGH);
    end

endmodule

// File: rtl/dmaq_reg_file.sv
module dmaq_reg_file
    import dmaq_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_end,
    input  logic                              wr_wrp,
    input  logic                              wr_ctrl,
    input  logic                              wr_plain,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [WORD_W-1:0]                 wdata,
    input  logic                              complete,
    input  logic                              clear_done,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words
);

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (g == IDX_END || g == IDX_WRP) begin : g_ptr
            logic hit;
            assign hit = (g == IDX_END) ? wr_end : wr_wrp;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   words[g] <= '0;
                else if (hit) words[g] <= wdata & PTR_KEEP;
            end
        end else if (g == IDX_RDP) begin : g_rdp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      words[g] <= '0;
                else if (wr_wrp) words[g] <= wdata & PTR_KEEP;
            end
        end else if (g == IDX_CTRL) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       words[g] <= '0;
                else if (wr_ctrl) words[g] <= wdata & CTRL_KEEP;
            end
        end else if (g == IDX_STAT) begin : g_stat
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          words[g] <= STAT_INIT;
                else if (complete)   words[g] <= words[g] | DONE_BITS;
                else if (clear_done) words[g] <= words[g] & ~DONE_BITS;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 words[g] <= '0;
                else if (wr_plain && idx == IDX_W'(g))      words[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dmaq_regif.sv
module dmaq_regif
    import dmaq_pkg::*;
#(
    parameter int unsigned BUS_AW    = 10,
    parameter int unsigned NUM_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              irq
);

    bus_dec_t                         dec;
    logic [IDX_W-1:0]                 idx;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic                             sup_armed;
    logic                             complete;
    logic                             arm_write;
    logic                             clear_done;
    logic                             enable_any;

    dmaq_bus_decode #(.BUS_AW(BUS_AW), .NUM_WORDS(NUM_WORDS)) u_dec (
        .req  (req),
        .we   (we),
        .addr (addr),
        .dec  (dec),
        .idx  (idx)
    );

    assign arm_write  = dec.wr_rdp && (wr_data == ARM_WORD);
    assign clear_done = dec.wr_stat && (|(wr_data & DONE_BITS));
    assign enable_any = |(words[IDX_CTRL] & DONE_BITS);

    dmaq_suppress_fsm u_sup (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_write (arm_write),
        .wrp_write (dec.wr_wrp),
        .armed     (sup_armed),
        .complete  (complete)
    );

    dmaq_irq_fsm u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .complete   (complete),
        .enable_any (enable_any),
        .clear      (clear_done),
        .irq        (irq)
    );

    dmaq_reg_file #(.NUM_WORDS(NUM_WORDS)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_end     (dec.wr_end),
        .wr_wrp     (dec.wr_wrp),
        .wr_ctrl    (dec.wr_ctrl),
        .wr_plain   (dec.wr_plain),
        .idx        (idx),
        .wdata      (wr_data),
        .complete   (complete),
        .clear_done (clear_done),
        .words      (words)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= dec.rd;
            if (dec.rd) rd_data <= dec.in_range ? words[idx] : '0;
        end
    end

endmodule

// File: rtl/dmaq_regif_chk.sv
module dmaq_regif_chk
    import dmaq_pkg::*;
#(
    parameter int unsigned BUS_AW = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [BUS_AW-1:0] addr,
    input logic [31:0]       wr_data,
    input logic              rd_valid,
    input logic              irq,
    input logic              armed
);

    logic wrp_wr, stat_clr, arm_wr, rd_req;
    assign rd_req   = req && !we;
    assign wrp_wr   = req && we && (addr == BUS_AW'(IDX_WRP));
    assign stat_clr = req && we && (addr == BUS_AW'(IDX_STAT)) && (|wr_data[5:4]);
    assign arm_wr   = req && we && (addr == BUS_AW'(IDX_RDP)) && (wr_data == ARM_WORD);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);  // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);  // R2
    AST_ARM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> armed);  // R5
    AST_RISE_NEEDS_WRP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wrp_wr));  // R6
    AST_ARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wrp_wr && armed) |=> ($stable(irq) && !armed));  // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> !irq);  // R9

endmodule

bind dmaq_regif dmaq_regif_chk #(.BUS_AW(BUS_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_valid (rd_valid),
    .irq      (irq),
    .armed    (sup_armed)
);

// File: tb/dmaq_regif_tb_top.sv
`timescale 1ns/1ps
module dmaq_regif_tb_top;

    localparam int BUS_AW = 10;
    localparam real HALF  = 4.0;   // 125 MHz

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [BUS_AW-1:0] addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic              rd_valid;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(HALF) clk = ~clk;

    dmaq_regif #(.BUS_AW(BUS_AW), .NUM_WORDS(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
    );

    // Monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected rd_valid, actual %08h expected none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s read actual %08h expected %08h", t, rd_data, e);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        req = 1'b1; we = 1'b1; addr = BUS_AW'(a); wr_data = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected item
    task automatic rd(input int a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        req = 1'b1; we = 1'b0; addr = BUS_AW'(a);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s actual %0b expected %0b", t, act, e);
        end
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_bit(irq, 1'b0, "R1 irq");
        chk_bit(rd_valid, 1'b0, "R1 rd_valid");
        rd(9, 32'hF800_0000, "R1 status");
        rd(8, 32'h0, "R1 ctrl");
        rd(5, 32'h0, "R1 end");
        rd(6, 32'h0, "R1 wrp");
        rd(7, 32'h0, "R1 rdp");
        rd(0, 32'h0, "R1 word0");
        @(negedge clk);
        chk_bit(rd_valid, 1'b0, "R2 idle valid");

        // R3 end pointer masking
        wr(5, 32'hFFFF_FFFF);
        rd(5, 32'h0003_FFFF, "R3");

        // R8 control masking
        wr(8, 32'hFFFF_FFFF);
        rd(8, 32'hBFEF_F07F, "R8");
        wr(8, 32'h0);

        // R12 completion with enables clear; R4 copy
        wr(6, 32'h1234_5678);
        chk_bit(irq, 1'b0, "R12 irq");
        rd(9, 32'hF800_0030, "R12 status");
        rd(6, 32'h0000_5678, "R4 wrp");
        rd(7, 32'h0000_5678, "R4 rdp");
        wr(9, 32'h30);
        rd(9, 32'hF800_0000, "R9 clear");

        // R6 completion with bit 4 enable
        wr(8, 32'h10);
        wr(6, 32'h100);
        chk_bit(irq, 1'b1, "R6 irq bit4");
        rd(9, 32'hF800_0030, "R6 status");

        // R9 write without bits 4/5 has no effect
        wr(9, 32'hFFFF_FFCF);
        chk_bit(irq, 1'b1, "R9 no-clear irq");
        rd(9, 32'hF800_0030, "R9 no-clear status");
        wr(9, 32'h20);
        chk_bit(irq, 1'b0, "R9 irq drop");
        rd(9, 32'hF800_0000, "R9 status");

        // R5 non-arming write ignored
        wr(7, 32'h1);
        rd(7, 32'h100, "R5 rdp unchanged");
        wr(6, 32'h200);
        chk_bit(irq, 1'b1, "R5 not armed");
        wr(9, 32'h10);
        chk_bit(irq, 1'b0, "R9 irq drop2");

        // R5/R7 arming word
        wr(7, 32'hEE88_2266);
        rd(7, 32'h200, "R5 rdp after arm");
        wr(6, 32'h300);
        chk_bit(irq, 1'b0, "R7 suppressed irq");
        rd(9, 32'hF800_0000, "R7 status");
        rd(7, 32'h300, "R4 rdp copy while armed");
        wr(6, 32'h304);
        chk_bit(irq, 1'b1, "R7 one-shot");
        wr(9, 32'h30);

        // R6 completion with bit 5 enable only
        wr(8, 32'h20);
        wr(6, 32'h8);
        chk_bit(irq, 1'b1, "R6 irq bit5");
        wr(9, 32'h30);
        chk_bit(irq, 1'b0, "R9 irq drop3");

        // R10 plain storage
        wr(0, 32'hDEAD_BEEF);
        wr(4, 32'hA5A5_0F0F);
        wr(31, 32'h1357_9BDF);
        rd(0, 32'hDEAD_BEEF, "R10 word0");
        rd(4, 32'hA5A5_0F0F, "R10 base");
        rd(31, 32'h1357_9BDF, "R10 word31");

        // R11 out of range
        wr(32, 32'hFFFF_FFFF);
        wr(36, 32'h0);
        rd(32, 32'h0, "R11 read 32");
        rd(1023, 32'h0, "R11 read 1023");
        rd(0, 32'hDEAD_BEEF, "R11 no alias 0");
        rd(4, 32'hA5A5_0F0F, "R11 no alias 4");

        repeat (3) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing reads actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule